// File: doc/BRIEF.md
# Ethernet Pause Frame Request Controller

This block sits beside the transmit path of an Ethernet MAC and decides when that transmitter should insert a pause control frame, and with which 16-bit pause time. The host programs it through a small register port: a 2-bit flow control command in a control register, and a 16-bit pause time register. The control register also returns a read-only copy of the MAC duplex setting. Bits 7:3 of the control register always read as zero.

In full duplex the command selects one of four actions. 00 turns flow control off. 01 asks for one pause frame. 10 asks for pause frames at a regular interval. 11 asks for one final frame carrying a zero pause time. A request is held on `tx_req_o` until the transmitter grants it. The transmitter grants only at its single arbitration point between host frames, so ordinary host traffic is never cut. After the grant of a single-frame or zero-value request, the command clears itself to 00.

In periodic mode a refresh counter counts pause quanta, one per pulse of `quanta_tick_i`. It is reloaded with a fraction of the programmed pause time, so the remote node is paused again before its timer expires. In half duplex no pause frames are requested. Instead, bit 0 of the command drives a backpressure enable.

Top module: `pause_req_ctrl`

## Requirements
- R1: After reset, the control register reads 00h, the pause time register reads 0000h, and both `tx_req_o` and `backpressure_o` are 0.
- R2: Control register bit 2 shows the value `full_duplex_i` had at the previous rising clock edge (1 = full duplex, 0 = half). All mode decisions use this registered copy. Bits 7:3 read 0.
- R3: In full duplex with command 00, `tx_req_o` stays 0.
- R4: In full duplex, writing command 01 raises `tx_req_o` in the next cycle, with `tx_ptime_o` equal to the pause time register. The request holds until a cycle with `tx_grant_i`=1. In the cycle after that grant, `tx_req_o` is 0 and the command reads 00.
- R5: In full duplex, command 11 requests one frame with `tx_ptime_o` = 0000h. In the cycle after its grant, the command reads 00.
- R6: In full duplex, writing command 10 raises `tx_req_o` at once, with `tx_ptime_o` equal to the pause time register. A grant drops the request and loads a refresh counter with max(pause_time >> REFRESH_SHIFT, 1) quanta. The request rises again in the cycle after the quantum pulse that brings the counter to zero. The command stays 10.
- R7: In half duplex, `tx_req_o` is 0, and `backpressure_o` equals command bit 0 (01 and 11 on; 00 and 10 off). In full duplex `backpressure_o` is 0.
- R8: A grant while `tx_req_o` is 0 has no effect. A host write to the control register in the same cycle as a grant takes priority over the automatic clear.
- R9: A write with `reg_sel_i`=1 loads `reg_wdata_i` into the pause time register. The register reads back on `ptime_rdata_o` and is used for the next non-zero request.
- R10: Writing command 00 while a periodic request is pending drops `tx_req_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex_i | input | 1 | MAC duplex setting, 1 = full duplex |
| quanta_tick_i | input | 1 | One pulse per 512 bit times |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = control register, 1 = pause time register |
| reg_wdata_i | input | 16 | Write data (command in bits 1:0) |
| ctrl_rdata_o | output | 8 | Control register: bit 2 duplex copy, bits 1:0 command |
| ptime_rdata_o | output | 16 | Pause time register |
| tx_req_o | output | 1 | Pause frame request to the transmitter |
| tx_grant_i | input | 1 | Transmitter accepts the pending request |
| tx_ptime_o | output | 16 | Pause time for the requested frame |
| backpressure_o | output | 1 | Half-duplex backpressure enable |

## Verification
A command register stuck in a state shows up at the control read port in the cycle after the grant that should have cleared it. A request that drops early or never rises is visible on `tx_req_o` within one cycle of the write. A refresh counter loaded with the wrong value moves the next periodic request by at least one quantum pulse. The bench counts those pulses exactly. A wrong duplex copy shows up one cycle after the input changes, both in bit 2 and as the wrong choice between request and backpressure.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    FC_OFF      = 2'b00,
    FC_ONCE     = 2'b01,
    FC_PERIODIC = 2'b10,
    FC_ZERO     = 2'b11
  } fc_cmd_e;
endpackage

// File: rtl/pfc_regs.sv
module pfc_regs
  import pfc_pkg::*;
#(
  parameter int unsigned PTIME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               full_duplex_i,
  input  logic               wr_i,
  input  logic               sel_i,
  input  logic [PTIME_W-1:0] wdata_i,
  input  logic               grant_acc_i,
  output fc_cmd_e            cmd_o,
  output logic [PTIME_W-1:0] ptime_o,
  output logic               dup_o
);
  fc_cmd_e            cmd_q, cmd_d;
  logic               cmd_en;
  logic [PTIME_W-1:0] ptime_q;
  logic               ptime_en;
  logic               dup_q;

  // next state: host write has priority over the self-clear
  always_comb begin
    cmd_d  = cmd_q;
    cmd_en = 1'b0;
    if (wr_i && !sel_i) begin
      cmd_d  = fc_cmd_e'(wdata_i[1:0]);
      cmd_en = 1'b1;
    end else if (grant_acc_i && dup_q && (cmd_q == FC_ONCE || cmd_q == FC_ZERO)) begin
      cmd_d  = FC_OFF;
      cmd_en = 1'b1;
    end
  end

  assign ptime_en = wr_i && sel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= FC_OFF;
      ptime_q <= '0;
      dup_q   <= 1'b0;
    end else begin
      dup_q <= full_duplex_i;
      if (cmd_en)   cmd_q   <= cmd_d;
      if (ptime_en) ptime_q <= wdata_i;
    end
  end

  assign cmd_o   = cmd_q;
  assign ptime_o = ptime_q;
  assign dup_o   = dup_q;

  // R4/R5: a granted one-shot command returns to off unless the host writes
  a_r4_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_acc_i && !(wr_i && !sel_i) && (cmd_q == FC_ONCE || cmd_q == FC_ZERO))
      |=> (cmd_q == FC_OFF));

  // R8: without a write and without a grant the command holds
  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !grant_acc_i) |=> $stable(cmd_q));
endmodule

// File: rtl/pfc_refresh.sv
module pfc_refresh #(
  parameter int unsigned PTIME_W       = 16,
  parameter int unsigned REFRESH_SHIFT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active_i,
  input  logic               start_i,
  input  logic               grant_acc_i,
  input  logic               tick_i,
  input  logic [PTIME_W-1:0] ptime_i,
  output logic               due_o
);
  logic [PTIME_W-1:0] cnt_q, cnt_d, reload;
  logic               due_q, due_d;

  always_comb begin
    reload = ptime_i >> REFRESH_SHIFT;
    if (reload == '0) reload = {{(PTIME_W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    cnt_d = cnt_q;
    due_d = due_q;
    if (start_i) begin
      due_d = 1'b1;
      cnt_d = '0;
    end else if (!active_i) begin
      due_d = 1'b0;
      cnt_d = '0;
    end else if (grant_acc_i) begin
      due_d = 1'b0;
      cnt_d = reload;
    end else if (tick_i && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == {{(PTIME_W-1){1'b0}}, 1'b1}) due_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      due_q <= due_d;
    end
  end

  assign due_o = due_q;

  // R6: a due request stays due until granted while periodic mode lasts
  a_r6_due_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (due_q && active_i && !grant_acc_i) |=> due_q);

  // R6: a grant always arms a non-zero refresh count
  a_r6_reload_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_acc_i && active_i && !start_i) |=> (cnt_q != '0 && !due_q));
endmodule

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl
  import pfc_pkg::*;
#(
  parameter int unsigned PTIME_W       = 16,
  parameter int unsigned REFRESH_SHIFT = 1,
  parameter int unsigned CTRL_W        = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               full_duplex_i,
  input  logic               quanta_tick_i,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [PTIME_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0]  ctrl_rdata_o,
  output logic [PTIME_W-1:0] ptime_rdata_o,
  output logic               tx_req_o,
  input  logic               tx_grant_i,
  output logic [PTIME_W-1:0] tx_ptime_o,
  output logic               backpressure_o
);
  localparam int unsigned PAD_W = CTRL_W - 3;

  fc_cmd_e            cmd;
  logic [PTIME_W-1:0] ptime;
  logic               dup;
  logic               due;
  logic               grant_acc;
  logic               periodic_act;
  logic               start_periodic;

  assign grant_acc      = tx_req_o && tx_grant_i;
  assign periodic_act   = dup && (cmd == FC_PERIODIC);
  assign start_periodic = reg_wr_i && !reg_sel_i && (reg_wdata_i[1:0] == 2'b10);

  pfc_regs #(.PTIME_W(PTIME_W)) i_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .full_duplex_i (full_duplex_i),
    .wr_i          (reg_wr_i),
    .sel_i         (reg_sel_i),
    .wdata_i       (reg_wdata_i),
    .grant_acc_i   (grant_acc),
    .cmd_o         (cmd),
    .ptime_o       (ptime),
    .dup_o         (dup)
  );

  pfc_refresh #(.PTIME_W(PTIME_W), .REFRESH_SHIFT(REFRESH_SHIFT)) i_refresh (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (periodic_act),
    .start_i     (start_periodic),
    .grant_acc_i (grant_acc),
    .tick_i      (quanta_tick_i),
    .ptime_i     (ptime),
    .due_o       (due)
  );

  // request and value selection
  always_comb begin
    tx_req_o       = 1'b0;
    tx_ptime_o     = ptime;
    backpressure_o = 1'b0;
    if (dup) begin
      unique case (cmd)
        FC_ONCE:     tx_req_o = 1'b1;
        FC_PERIODIC: tx_req_o = due;
        FC_ZERO: begin
          tx_req_o   = 1'b1;
          tx_ptime_o = '0;
        end
        default:     tx_req_o = 1'b0;
      endcase
    end else begin
      backpressure_o = cmd[0];
    end
  end

  assign ctrl_rdata_o  = {{PAD_W{1'b0}}, dup, cmd};
  assign ptime_rdata_o = ptime;

  // R4: a request is held until granted (duplex and command unchanged)
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_o && !tx_grant_i && !reg_wr_i && full_duplex_i) |=> tx_req_o);

  // R7: half duplex never requests a frame
  a_r7_no_req_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata_o[2]) |-> !tx_req_o);

  // R7: full duplex never asserts backpressure
  a_r7_no_bp_full: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata_o[2] |-> !backpressure_o);

  // R5: the final request carries a zero pause time
  a_r5_zero_value: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_o && ctrl_rdata_o[1:0] == 2'b11) |-> (tx_ptime_o == '0));

  // R2: the duplex copy follows the input one edge later
  a_r2_dup_copy: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (ctrl_rdata_o[2] == $past(full_duplex_i)));
endmodule

// File: tb/test_pause_req_ctrl.sv
module test_pause_req_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        full_duplex_i;
  logic        quanta_tick_i;
  logic        reg_wr_i;
  logic        reg_sel_i;
  logic [15:0] reg_wdata_i;
  logic [7:0]  ctrl_rdata_o;
  logic [15:0] ptime_rdata_o;
  logic        tx_req_o;
  logic        tx_grant_i;
  logic [15:0] tx_ptime_o;
  logic        backpressure_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pause_req_ctrl i_pause_req_ctrl (
    .clk(clk), .rst_n(rst_n), .full_duplex_i(full_duplex_i),
    .quanta_tick_i(quanta_tick_i), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .ctrl_rdata_o(ctrl_rdata_o),
    .ptime_rdata_o(ptime_rdata_o), .tx_req_o(tx_req_o), .tx_grant_i(tx_grant_i),
    .tx_ptime_o(tx_ptime_o), .backpressure_o(backpressure_o)
  );

  typedef struct packed {
    logic        dup;
    logic [1:0]  cmd;
    logic [15:0] pt;
    logic        ereq;
    logic        ebp;
    logic [15:0] etp;
    logic [1:0]  ecmd;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 2'b00, 16'h1234, 1'b0, 1'b0, 16'h0000, 2'b00},
    '{1'b1, 2'b01, 16'h1234, 1'b1, 1'b0, 16'h1234, 2'b00},
    '{1'b1, 2'b11, 16'h1234, 1'b1, 1'b0, 16'h0000, 2'b00},
    '{1'b1, 2'b10, 16'h0040, 1'b1, 1'b0, 16'h0040, 2'b10},
    '{1'b0, 2'b00, 16'hABCD, 1'b0, 1'b0, 16'h0000, 2'b00},
    '{1'b0, 2'b01, 16'hABCD, 1'b0, 1'b1, 16'h0000, 2'b01},
    '{1'b0, 2'b10, 16'hABCD, 1'b0, 1'b0, 16'h0000, 2'b10},
    '{1'b0, 2'b11, 16'hABCD, 1'b0, 1'b1, 16'h0000, 2'b11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    step();
    reg_wr_i = 1'b0; reg_sel_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic grant();
    tx_grant_i = 1'b1;
    step();
    tx_grant_i = 1'b0;
  endtask

  task automatic tick();
    quanta_tick_i = 1'b1;
    step();
    quanta_tick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; full_duplex_i = 1'b0; quanta_tick_i = 1'b0;
    reg_wr_i = 1'b0; reg_sel_i = 1'b0; reg_wdata_i = '0; tx_grant_i = 1'b0;
    step(); step();
    // R1 reset state
    chk("R1 ctrl", ctrl_rdata_o, 8'h00);
    chk("R1 ptime", ptime_rdata_o, 16'h0);
    chk("R1 req", tx_req_o, 1'b0);
    chk("R1 bp", backpressure_o, 1'b0);
    rst_n = 1'b1;
    step();

    // table walk
    foreach (VECS[i]) begin
      full_duplex_i = VECS[i].dup;
      step(); step();
      chk("R2 dup bit", ctrl_rdata_o[2], VECS[i].dup);
      chk("R2 upper zero", ctrl_rdata_o[7:3], 5'd0);
      wr(1'b1, VECS[i].pt);
      chk("R9 ptime readback", ptime_rdata_o, VECS[i].pt);
      wr(1'b0, {14'd0, VECS[i].cmd});
      chk("R3/R4/R5/R6/R7 req", tx_req_o, VECS[i].ereq);
      chk("R7 bp", backpressure_o, VECS[i].ebp);
      if (VECS[i].ereq) chk("R4/R5/R6 ptime out", tx_ptime_o, VECS[i].etp);
      grant();
      chk("R4/R5/R8 cmd after grant", ctrl_rdata_o[1:0], VECS[i].ecmd);
      chk("R4/R5/R6 req after grant", tx_req_o, 1'b0);
      wr(1'b0, 16'h0000);
    end

    // R2 duplex copy lags by one edge
    full_duplex_i = 1'b0; step();
    full_duplex_i = 1'b1;
    chk("R2 before edge", ctrl_rdata_o[2], 1'b0);
    step();
    chk("R2 after edge", ctrl_rdata_o[2], 1'b1);

    // R4 hold without grant
    wr(1'b1, 16'h0777);
    wr(1'b0, 16'h0001);
    for (int k = 0; k < 5; k++) step();
    chk("R4 held", tx_req_o, 1'b1);
    chk("R4 value", tx_ptime_o, 16'h0777);
    // R8 write wins over grant in the same cycle
    reg_wr_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 16'h0002; tx_grant_i = 1'b1;
    step();
    reg_wr_i = 1'b0; reg_wdata_i = '0; tx_grant_i = 1'b0;
    chk("R8 write priority", ctrl_rdata_o[1:0], 2'b10);
    chk("R6 start req", tx_req_o, 1'b1);
    wr(1'b0, 16'h0000);

    // R6 periodic timing: ptime 8 -> reload 4
    wr(1'b1, 16'h0008);
    wr(1'b0, 16'h0002);
    chk("R6 first req", tx_req_o, 1'b1);
    grant();
    chk("R6 dropped", tx_req_o, 1'b0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6 waiting", tx_req_o, 1'b0);
    end
    step();
    chk("R6 no tick no req", tx_req_o, 1'b0);
    tick();
    chk("R6 re-request", tx_req_o, 1'b1);
    chk("R6 cmd stays", ctrl_rdata_o[1:0], 2'b10);
    // R10 turn off while pending
    wr(1'b0, 16'h0000);
    chk("R10 off", tx_req_o, 1'b0);

    // R6 minimum reload of one quantum: ptime 1
    wr(1'b1, 16'h0001);
    wr(1'b0, 16'h0002);
    grant();
    chk("R6 min dropped", tx_req_o, 1'b0);
    tick();
    chk("R6 min re-request", tx_req_o, 1'b1);
    chk("R9 value used", tx_ptime_o, 16'h0001);
    wr(1'b0, 16'h0000);

    // R3 grant with no request is harmless
    grant();
    chk("R3 idle", tx_req_o, 1'b0);
    chk("R8 idle cmd", ctrl_rdata_o[1:0], 2'b00);

    done = 1'b1;
    finish_run();
  end
endmodule